// File: doc/BRIEF.md
# Request/Acknowledge Clock-Domain Word Transfer

This block carries one data word at a time from a sending clock domain (`x_clk`) to a receiving clock domain (`y_clk`). The clocks are unrelated. On the sending side, a one-cycle `x_send` strobe hands a word to the block. The block registers the word and holds it on an internal bus. It then raises a request line. The request crosses into the receiving domain through a chain of synchronizer flops. When the receiver sees the synchronized request rise, it captures the bus, emits a one-cycle `y_valid` pulse and raises an acknowledge. The acknowledge crosses back into the sending domain through its own synchronizer chain.

The loop is four-phase. The sender drops its request once the synchronized acknowledge is high. The receiver drops the acknowledge once the synchronized request has fallen. The sender accepts the next word only after it sees the acknowledge low again. `x_busy` covers this whole sequence, and a strobe that arrives while it is high is dropped. Because the bus is never changed while the request or acknowledge is in flight, the receiver always samples a settled word. The cost is several clocks of each domain per word.

Top module: `hs_xfer`

## Requirements
- R1: While either reset is asserted (active low), `x_busy` is 0, `y_valid` is 0 and `y_data` is all zeros.
- R2: A strobe on `x_send` in an `x_clk` cycle where `x_busy` is 0 is accepted. `x_busy` reads 1 after that rising edge.
- R3: Each accepted word appears on `y_data` exactly once, in the order accepted, with `y_valid` high in the same `y_clk` cycle. No `y_valid` pulse occurs without a matching accepted word.
- R4: `y_valid` is high for exactly one `y_clk` cycle per word. `y_data` changes only in a cycle where `y_valid` is 1 and otherwise holds the last delivered word.
- R5: A strobe on `x_send` while `x_busy` is 1 has no effect. It produces no delivery and does not change the word in flight.
- R6: The word delivered equals the `x_data` value present on the accepting edge, even if `x_data` changes afterwards. The request stays high until the synchronized acknowledge is seen.
- R7: `x_busy` stays high until the acknowledge has returned low, which takes at least 2*SYNC_STAGES `x_clk` cycles. The word has already been delivered when `x_busy` falls, and a new strobe is accepted in the first cycle `x_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_clk | input | 1 | Sending-domain clock |
| x_rst_n | input | 1 | Sending-domain reset, active low, asynchronous |
| x_send | input | 1 | Strobe: hand `x_data` to the block |
| x_data | input | DATA_W | Word offered with the strobe |
| x_busy | output | 1 | A transfer is in progress; strobes are ignored |
| y_clk | input | 1 | Receiving-domain clock |
| y_rst_n | input | 1 | Receiving-domain reset, active low, asynchronous |
| y_valid | output | 1 | One-cycle pulse: a new word is on `y_data` |
| y_data | output | DATA_W | Last delivered word |

## Verification
The hardest case to reach from the ports is a strobe that arrives while a transfer is still closing. The request has dropped, but the acknowledge is still high in the sending domain. The bench pokes `x_send` with a distinct word in every busy cycle of selected transfers. It also issues the next real strobe in the very first cycle `x_busy` falls. It runs these patterns with a receiving clock faster than the sending clock, then with one much slower, so both ordering extremes of the synchronizers are covered.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
   typedef enum logic [1:0] {
      TX_IDLE    = 2'd0,
      TX_REQ     = 2'd1,
      TX_RELEASE = 2'd2
   } tx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_sender.sv
module hs_sender
   import hs_xfer_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ack_s,
   output logic              req,
   output logic [DATA_W-1:0] word,
   output logic              busy
);
   tx_state_e         state_q;
   logic              req_q;
   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         req_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         case (state_q)
            TX_IDLE: if (send) begin
               word_q  <= data_in;
               req_q   <= 1'b1;
               state_q <= TX_REQ;
            end
            TX_REQ: if (ack_s) begin
               req_q   <= 1'b0;
               state_q <= TX_RELEASE;
            end
            TX_RELEASE: if (!ack_s) state_q <= TX_IDLE;
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign req  = req_q;
   assign word = word_q;
   assign busy = (state_q != TX_IDLE);

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !ack_s) |=> req_q);
   // R6
   word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(word_q));
   // R5
   busy_send_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (send && busy) |=> $stable(word_q));
   // R7
   release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_s && busy) |=> busy);
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_s,
   input  logic [DATA_W-1:0] bus,
   output logic              ack,
   output logic              valid,
   output logic [DATA_W-1:0] data_out
);
   logic              ack_q;
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              req_rise;

   assign req_rise = req_s && !ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         ack_q   <= req_s;
         valid_q <= req_rise;
         if (req_rise) data_q <= bus;
      end
   end

   assign ack      = ack_q;
   assign valid    = valid_q;
   assign data_out = data_q;

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
   // R4
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> $stable(data_q));
   // R3
   ack_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> valid_q);
endmodule

// File: rtl/hs_xfer.sv
module hs_xfer #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              x_clk,
   input  logic              x_rst_n,
   input  logic              x_send,
   input  logic [DATA_W-1:0] x_data,
   output logic              x_busy,
   input  logic              y_clk,
   input  logic              y_rst_n,
   output logic              y_valid,
   output logic [DATA_W-1:0] y_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs_xfer: DATA_W must be positive");
      end
   endgenerate

   logic              x_req;
   logic              x_ack_s;
   logic [DATA_W-1:0] x_word;
   logic              y_req_s;
   logic              y_ack;

   hs_sender #(.DATA_W(DATA_W)) u_tx (
      .clk(x_clk), .rst_n(x_rst_n), .send(x_send), .data_in(x_data),
      .ack_s(x_ack_s), .req(x_req), .word(x_word), .busy(x_busy));

   hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(y_clk), .rst_n(y_rst_n), .d(x_req), .q(y_req_s));

   hs_receiver #(.DATA_W(DATA_W)) u_rx (
      .clk(y_clk), .rst_n(y_rst_n), .req_s(y_req_s), .bus(x_word),
      .ack(y_ack), .valid(y_valid), .data_out(y_data));

   hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(x_clk), .rst_n(x_rst_n), .d(y_ack), .q(x_ack_s));
endmodule

// File: tb/hs_xfer_test.sv
module hs_xfer_test;
   localparam int W = 16;
   localparam int STG = 2;

   logic         x_clk = 1'b0, y_clk = 1'b0;
   logic         x_rst_n = 1'b0, y_rst_n = 1'b0;
   logic         x_send = 1'b0;
   logic [W-1:0] x_data = '0;
   logic         x_busy, y_valid;
   logic [W-1:0] y_data;
   int           yhalf = 7;

   int tests = 0, fails = 0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] last_word = '0;
   logic         prev_valid = 1'b0;
   int           busy_len = 0;
   bit           done = 0;

   hs_xfer #(.DATA_W(W), .SYNC_STAGES(STG)) uut (
      .x_clk(x_clk), .x_rst_n(x_rst_n), .x_send(x_send), .x_data(x_data),
      .x_busy(x_busy), .y_clk(y_clk), .y_rst_n(y_rst_n),
      .y_valid(y_valid), .y_data(y_data));

   always #10 x_clk = ~x_clk;
   always #(yhalf) y_clk = ~y_clk;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // receiving-side reference: compared every y_clk
   always @(negedge y_clk) if (y_rst_n && !done) begin
      if (y_valid) begin
         check(!prev_valid, "R4 valid longer than one cycle", 1, 0);
         if (exp_q.size() == 0) check(0, "R3 unexpected delivery", y_data, 0);
         else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            check(y_data == e, "R3/R6 delivered word", y_data, e);
         end
         last_word = y_data;
      end else begin
         check(y_data == last_word, "R4 data hold", y_data, last_word);
      end
      prev_valid = y_valid;
   end

   // sending-side reference: busy duration and completion
   always @(negedge x_clk) if (x_rst_n && !done) begin
      if (x_busy) busy_len++;
      else if (busy_len > 0) begin
         check(busy_len >= 2*STG, "R7 busy length", busy_len, 2*STG);
         check(exp_q.size() == 0, "R7 delivered before release", exp_q.size(), 0);
         busy_len = 0;
      end
   end

   task automatic send_word(input logic [W-1:0] w, input bit poke);
      while (x_busy) begin
         @(negedge x_clk); #1;
      end
      x_send = 1'b1;
      x_data = w;
      exp_q.push_back(w);
      @(negedge x_clk); #1;
      check(x_busy == 1'b1, "R2 busy after accept", x_busy, 1);
      x_data = ~w;                       // R6: bus input changes after accept
      if (!poke) x_send = 1'b0;
      while (x_busy) begin               // R5: strobes while busy
         if (poke) x_data = x_data + 16'h0101;
         @(negedge x_clk); #1;
      end
      x_send = 1'b0;
   endtask

   task automatic drain;
      repeat (40) @(negedge y_clk);
      check(exp_q.size() == 0, "R5 no extra/missing deliveries", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge x_clk);
      // R1 reset state
      check(x_busy == 1'b0, "R1 busy in reset", x_busy, 0);
      check(y_valid == 1'b0, "R1 valid in reset", y_valid, 0);
      check(y_data == '0, "R1 data in reset", y_data, 0);
      #1; x_rst_n = 1'b1; y_rst_n = 1'b1;
      repeat (2) @(negedge x_clk); #1;
      check(x_busy == 1'b0, "R1 idle after reset", x_busy, 0);

      // fast receiver
      for (int i = 0; i < 20; i++) send_word(16'h1000 + 16'(i*37), 1'b0);
      for (int i = 0; i < 10; i++) send_word(16'hA500 ^ 16'(i), (i % 2) == 0);
      drain();
      // slow receiver
      @(negedge x_clk); yhalf = 37;
      repeat (10) @(negedge y_clk);
      for (int i = 0; i < 15; i++) send_word(16'(i*4099), 1'b0);
      for (int i = 0; i < 10; i++) send_word(16'hFFFF - 16'(i), 1'b1);
      send_word(16'h0000, 1'b1);
      send_word(16'hFFFF, 1'b0);
      drain();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge x_clk);
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule